// File: doc/BRIEF.md
# PLL Divider and Multiplier Setting Search

This block picks the settings of a frequency synthesizer. A caller gives a reference frequency and a target output frequency, both as unsigned integers in hertz, and raises `start` for one cycle. The engine then walks every combination of a 1-bit pre-divider code, a 3-bit post-divider shift and an 8-bit multiplier code. It tests one candidate per clock and keeps the candidate whose output comes closest to the target without going above it. When it finishes it raises `done` for one cycle and presents the chosen codes, the output frequency they give, and flags for an exact hit and for a target with no solution. It also presents a loop-filter band code and a warning for a divided reference outside the recommended window, and packs all of these into a single configuration word.

A candidate's output is `ref * (m+1) / ((d1+1) * 2^d2)`, rounded down. With d1 and d2 small, the divisor is always a power of two, so each candidate needs one multiply and one right shift and no divider. The search stops on the first exact hit. Otherwise it runs all 4096 candidates.

Top module: `pll_param_search`

## Requirements
- R1: After reset `busy`, `done`, `exact`, `no_solution`, `range_warn` and every result field and `cfg_word` are zero.
- R2: The reported output frequency is `floor(ref * (m+1) / ((d1+1) * 2^d2))` for the reported codes `m`, `d1` and `d2`.
- R3: Candidates are visited with `d1` going from 1 down to 0 in the outer loop, `d2` going from 7 down to 0 in the middle loop and `m` going from 0 up to 255 in the inner loop. The kept candidate changes only when a new candidate has a strictly smaller error, so among tied candidates the first one visited is reported.
- R4: A candidate whose output is above the target is never chosen, so the reported frequency is always at or below the target.
- R5: A candidate equal to the target ends the search at once and sets `exact`. The start-to-done latency in clock edges is the 1-based position of that candidate in the R3 order. A search with no exact hit takes 4096 edges.
- R6: `filter_code` is the band of F = floor(floor(ref/1e6)/(d1+1)) MHz. F of 166 or more gives 7, 104 or more gives 6, 65 or more gives 5, 42 or more gives 4, 26 or more gives 3, 16 or more gives 2, 10 or more gives 1, and anything lower gives 0.
- R7: `range_warn` is set when the F of R6 is below 10 or above 200.
- R8: `cfg_word` holds `filter_code` in bits 26:24, `m` in bits 23:16, `d1` in bit 8 and `d2` in bits 2:0. All other bits are zero.
- R9: `done` is high for exactly one cycle per accepted start. A `start` that arrives while `busy` is high is ignored. The results stay unchanged after `done` until the next start is accepted.
- R10: When every candidate is above the target, `no_solution` is set. The codes, the frequency, `filter_code`, `range_warn`, `exact` and `cfg_word` are then all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search. Sampled only while idle. |
| ref_hz | input | 32 | Reference frequency in Hz, captured at start |
| req_hz | input | 32 | Target output frequency in Hz, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| mult_code | output | 8 | Chosen multiplier code m |
| prediv_code | output | 1 | Chosen pre-divider code d1 |
| shift_code | output | 3 | Chosen post-divider shift d2 |
| achieved_hz | output | 32 | Output frequency of the chosen setting |
| exact | output | 1 | Chosen setting equals the target |
| no_solution | output | 1 | No candidate at or below the target |
| filter_code | output | 3 | Loop-filter band of the divided reference |
| range_warn | output | 1 | Divided reference outside 10 to 200 MHz |
| cfg_word | output | 32 | Packed configuration word |

## Verification
The two hardest cases to reach are the ones where the search order decides the answer. The first is a tie between candidates of equal error. The bench forces one by using a zero reference, which makes every candidate's output zero, so the first candidate visited must be reported. The second is an exact hit that only a late candidate can give. The bench reaches one by targeting 200 times the reference, which needs d1 = 0, d2 = 0 and m = 199, and by doing so it also checks the 4040-edge latency. Filter band edges are reached by targets that the very first candidate hits exactly, with the reference set on or just below 332 MHz.

// File: rtl/pll_param_search.sv
module pll_param_search #(
  parameter int              FREQ_W  = 32,
  parameter longint unsigned UNIT_HZ = 64'd1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] ref_hz,
  input  logic [FREQ_W-1:0] req_hz,
  output logic              busy,
  output logic              done,
  output logic [7:0]        mult_code,
  output logic              prediv_code,
  output logic [2:0]        shift_code,
  output logic [FREQ_W-1:0] achieved_hz,
  output logic              exact,
  output logic              no_solution,
  output logic [2:0]        filter_code,
  output logic              range_warn,
  output logic [31:0]       cfg_word
);

  localparam int M_W    = 8;
  localparam int D2_W   = 3;
  localparam int IDX_W  = 1 + D2_W + M_W;
  localparam int PROD_W = FREQ_W + M_W + 1;
  localparam int unsigned BAND_MHZ [7] = '{10, 16, 26, 42, 65, 104, 166};

  function automatic logic [2:0] band_of(input logic [FREQ_W-1:0] r, input logic half);
    logic [2:0] c;
    c = 3'd0;
    for (int i = 0; i < 7; i++)
      if (64'(r) >= 64'(BAND_MHZ[i]) * (half ? 64'd2 : 64'd1) * UNIT_HZ)
        c = 3'(i + 1);
    return c;
  endfunction

  function automatic logic window_miss(input logic [FREQ_W-1:0] r, input logic half);
    longint unsigned k;
    k = (half ? 64'd2 : 64'd1) * UNIT_HZ;
    return (64'(r) < 64'd10 * k) || (64'(r) >= 64'd201 * k);
  endfunction

  logic [FREQ_W-1:0] ref_q, req_q;
  logic [IDX_W-1:0]  idx;
  logic              busy_q, done_q, found_q;
  logic [M_W-1:0]    bm;
  logic              bd1;
  logic [D2_W-1:0]   bd2;
  logic [PROD_W-1:0] bt;

  logic [M_W-1:0]    res_m;
  logic              res_d1;
  logic [D2_W-1:0]   res_d2;
  logic [PROD_W-1:0] res_t;
  logic              res_exact, res_nosol, res_warn;
  logic [2:0]        res_filt;

  logic [M_W-1:0]    cur_m;
  logic              cur_d1;
  logic [D2_W-1:0]   cur_d2;
  logic [PROD_W-1:0] prod, tclk;
  logic              fits, hit, upd, fin;
  logic [M_W-1:0]    nm;
  logic              nd1;
  logic [D2_W-1:0]   nd2;
  logic [PROD_W-1:0] nt;

  assign cur_m  = idx[M_W-1:0];
  assign cur_d2 = ~idx[M_W +: D2_W];
  assign cur_d1 = ~idx[IDX_W-1];

  assign prod = PROD_W'(ref_q) * PROD_W'({1'b0, cur_m} + (M_W+1)'(1));
  assign tclk = prod >> ({3'b000, cur_d1} + {1'b0, cur_d2});
  assign fits = tclk <= PROD_W'(req_q);
  assign hit  = tclk == PROD_W'(req_q);
  assign upd  = fits && (!found_q || tclk > bt);
  assign fin  = busy_q && (hit || (&idx));

  assign nm  = upd ? cur_m  : bm;
  assign nd1 = upd ? cur_d1 : bd1;
  assign nd2 = upd ? cur_d2 : bd2;
  assign nt  = upd ? tclk   : bt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0; req_q <= '0; idx <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; found_q <= 1'b0;
      bm <= '0; bd1 <= 1'b0; bd2 <= '0; bt <= '0;
      res_m <= '0; res_d1 <= 1'b0; res_d2 <= '0; res_t <= '0;
      res_exact <= 1'b0; res_nosol <= 1'b0; res_warn <= 1'b0; res_filt <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          ref_q   <= ref_hz;
          req_q   <= req_hz;
          idx     <= '0;
          busy_q  <= 1'b1;
          found_q <= 1'b0;
          bm <= '0; bd1 <= 1'b0; bd2 <= '0; bt <= '0;
        end
      end else begin
        if (upd) begin
          bm <= cur_m; bd1 <= cur_d1; bd2 <= cur_d2; bt <= tclk;
          found_q <= 1'b1;
        end
        if (fin) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          res_m     <= nm;
          res_d1    <= nd1;
          res_d2    <= nd2;
          res_t     <= nt;
          res_exact <= hit;
          res_nosol <= !(found_q || fits);
          res_filt  <= (found_q || fits) ? band_of(ref_q, nd1) : 3'd0;
          res_warn  <= (found_q || fits) ? window_miss(ref_q, nd1) : 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign mult_code   = res_m;
  assign prediv_code = res_d1;
  assign shift_code  = res_d2;
  assign achieved_hz = res_t[FREQ_W-1:0];
  assign exact       = res_exact;
  assign no_solution = res_nosol;
  assign filter_code = res_filt;
  assign range_warn  = res_warn;
  assign cfg_word    = {5'b0, res_filt, res_m, 7'b0, res_d1, 5'b0, res_d2};

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R9
  AST_INPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ref_q) && $stable(req_q)) else $error("inputs changed mid-search"); // R9
  AST_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !no_solution |-> res_t <= PROD_W'(req_q)) else $error("result above target"); // R4
  AST_EXACT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    done && exact |-> res_t == PROD_W'(req_q)) else $error("exact flag without equality"); // R5
  AST_NOSOL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && no_solution |-> cfg_word == 32'd0 && achieved_hz == '0 && !exact) else $error("no-solution fields not zero"); // R10
  AST_BEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(found_q) |-> bt >= $past(bt)) else $error("kept candidate got worse"); // R3

endmodule

// File: tb/pll_param_search_tb.sv
module pll_param_search_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0, req_hz = '0;
  logic        busy, done, prediv_code, exact, no_solution, range_warn;
  logic [7:0]  mult_code;
  logic [2:0]  shift_code, filter_code;
  logic [31:0] achieved_hz, cfg_word;

  always #5 clk = ~clk;

  pll_param_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .req_hz(req_hz),
    .busy(busy), .done(done), .mult_code(mult_code), .prediv_code(prediv_code),
    .shift_code(shift_code), .achieved_hz(achieved_hz), .exact(exact),
    .no_solution(no_solution), .filter_code(filter_code), .range_warn(range_warn),
    .cfg_word(cfg_word)
  );

  typedef struct {
    logic [7:0]  m;
    logic        d1;
    logic [2:0]  d2;
    logic [31:0] t;
    logic        ex, ns, warn;
    logic [2:0]  filt;
    logic [31:0] word;
    int          lat;
    longint      s_cyc;
  } exp_t;

  exp_t   sb[$];
  exp_t   last;
  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [31:0] r, input logic [31:0] q);
    exp_t e;
    longint unsigned t, best, fmhz;
    bit found;
    e = '{m:0, d1:0, d2:0, t:0, ex:0, ns:0, warn:0, filt:0, word:0, lat:4096, s_cyc:0};
    found = 0; best = 0;
    for (int i = 0; i < 4096; i++) begin
      int d1, d2, m;
      d1 = 1 - i / 2048;
      d2 = 7 - (i / 256) % 8;
      m  = i % 256;
      t  = 64'(r) * 64'(m + 1) / (64'(d1 + 1) * (64'd1 << d2));
      if (t <= 64'(q) && (!found || t > best)) begin
        found = 1; best = t;
        e.m = 8'(m); e.d1 = 1'(d1); e.d2 = 3'(d2); e.t = 32'(t);
      end
      if (t == 64'(q)) begin
        e.ex = 1; e.lat = i + 1;
        break;
      end
    end
    e.ns = !found;
    if (found) begin
      fmhz = (64'(r) / 64'd1000000) / 64'(e.d1 + 1);
      if      (fmhz >= 166) e.filt = 7;
      else if (fmhz >= 104) e.filt = 6;
      else if (fmhz >= 65)  e.filt = 5;
      else if (fmhz >= 42)  e.filt = 4;
      else if (fmhz >= 26)  e.filt = 3;
      else if (fmhz >= 16)  e.filt = 2;
      else if (fmhz >= 10)  e.filt = 1;
      else                  e.filt = 0;
      e.warn = (fmhz < 10) || (fmhz > 200);
    end
    e.word = {5'b0, e.filt, e.m, 7'b0, e.d1, 5'b0, e.d2};
    return e;
  endfunction

  task automatic run(input logic [31:0] r, input logic [31:0] q);
    exp_t e;
    while (busy || done) @(negedge clk);
    e = model(r, q);
    e.s_cyc = cyc;
    sb.push_back(e);
    ref_hz = r; req_hz = q; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(0, "R9 done without accepted start", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        last = e;
        chk(mult_code == e.m, "R3 multiplier code", mult_code, e.m);
        chk(prediv_code == e.d1, "R3 pre-divider code", prediv_code, e.d1);
        chk(shift_code == e.d2, "R3 shift code", shift_code, e.d2);
        chk(achieved_hz == e.t, "R2 R4 achieved frequency", achieved_hz, e.t);
        chk(exact == e.ex, "R5 exact flag", exact, e.ex);
        chk(int'(cyc - e.s_cyc - 1) == e.lat, "R5 latency", cyc - e.s_cyc - 1, e.lat);
        chk(no_solution == e.ns, "R10 no-solution flag", no_solution, e.ns);
        chk(filter_code == e.filt, "R6 filter band", filter_code, e.filt);
        chk(range_warn == e.warn, "R7 range warning", range_warn, e.warn);
        chk(cfg_word == e.word, "R8 packed word", cfg_word, e.word);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done at reset", {busy, done}, 0);
    chk(cfg_word == 0 && achieved_hz == 0, "R1 result fields at reset", cfg_word, 0);
    chk(!exact && !no_solution && !range_warn, "R1 flags at reset", {exact, no_solution, range_warn}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'd24000000, 32'd93750);        // R5 exact at the first candidate
    run(32'd25000000, 32'd0);            // R10 nothing at or below target
    run(32'd332000000, 32'd1296875);     // R6 band 7 at the 166 MHz edge
    run(32'd331999999, 32'd1296874);     // R6 band 6 just below the edge
    run(32'd10000000, 32'd2000000000);   // R3 late exact hit with d1=0, d2=0
    run(32'd0, 32'd5);                   // R3 all candidates tie
    run(32'd0, 32'd0);                   // R5 zero reference, zero target
    run(32'hFFFFFFFF, 32'hFFFFFFFF);     // R2 widest values
    run(32'd5000000, 32'd77777777);      // R7 divided reference below window
    run(32'd25000000, 32'd600000000);    // R4 closest from below

    // R9 a start while busy is ignored
    run(32'd20000000, 32'd123456789);
    repeat (20) @(negedge clk);
    ref_hz = 32'd1000000; req_hz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy through ignored start", busy, 1);

    for (int k = 0; k < 8; k++)
      run(32'd1000000 + ($urandom % 32'd300000000), $urandom);

    while (busy || done) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(cfg_word == last.word, "R9 word held after done", cfg_word, last.word);
    chk(achieved_hz == last.t, "R9 frequency held after done", achieved_hz, last.t);
    chk(!done, "R9 done stays low when idle", done, 0);
    chk(sb.size() == 0, "R9 every start gave one done", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule